// File: doc/BRIEF.md
# Banked Register Operand Collector

This block sits between instruction issue and the execution units of a multithreaded SIMD core. An issued instruction names a warp, an opcode tag and up to three source registers. It is parked in one of several collector units, and that unit holds the register identifiers until the operand values have been read. The register file is a set of single-ported banks, not one wide multi-ported array. Each cycle a bank arbiter grants at most one access per bank. Reads from different instructions therefore interleave across the banks, and a writeback takes its bank ahead of any read in the same cycle.

The bank of a register is its number plus the warp index, modulo the bank count. The same register number in neighbouring warps therefore falls in different banks. When every operand of a unit has arrived, the unit presents its instruction on its own dispatch port for one cycle and then becomes free again. The register storage is a plain behavioural array that is filled through the writeback port.

Top module: `operand_collector`

## Requirements
- R1: `issue_ready` is high exactly when at least one collector unit is free. An issue with `issue_valid` and `issue_ready` both high is taken by the free unit with the lowest index. While `issue_ready` is low, `issue_valid` is ignored.
- R2: Register r of warp w sits in bank (r + w) mod NUM_BANKS. Sources in the same bank are read one per cycle, so three such sources delay dispatch by two cycles compared with sources in three different banks.
- R3: Sources in different banks are read in the same cycle. With all sources in distinct banks, the unit's `disp_valid` bit is high in the second cycle after the issue edge.
- R4: The warp-index swizzle lets a younger instruction of warp 1 read R4 in bank 1 while an older warp-0 instruction is still reading bank 0. The younger one dispatches without waiting.
- R5: A writeback wins its bank for that cycle and blocks every read of that bank. A read of the register that was written returns the new value.
- R6: When several units want the same bank, the one that was issued earliest gets it, whatever its index.
- R7: `disp_valid` for a unit is high for exactly one cycle. That cycle comes one cycle after the edge at which the last operand was captured. The unit is free again in the next cycle.
- R8: On dispatch, unit u presents the issued warp and opcode tag. It also presents source slot s at `disp_operands[(u*NSRC+s)*DATA_W +: DATA_W]` with the register value. A slot whose `issue_src_en` bit was 0 reads as zero. An instruction with no sources dispatches in the second cycle after issue. Source slot s of an issue is `issue_src[s*REG_W +: REG_W]`.
- R9: After reset all units are free, `issue_ready` is high and `disp_valid` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered for collection |
| issue_ready | output | 1 | A collector unit is free |
| issue_warp | input | WID_W | Warp index of the instruction |
| issue_op | input | OP_W | Opcode tag carried to dispatch |
| issue_src_en | input | NSRC | Which source slots are used |
| issue_src | input | NSRC*REG_W | Source register numbers, slot s in bits s*REG_W |
| wb_valid | input | 1 | Register writeback this cycle |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | REG_W | Register number of the writeback |
| wb_data | input | DATA_W | Value written |
| disp_valid | output | NUM_CU | Per-unit dispatch strobe |
| disp_warp | output | NUM_CU*WID_W | Per-unit warp index |
| disp_op | output | NUM_CU*OP_W | Per-unit opcode tag |
| disp_operands | output | NUM_CU*NSRC*DATA_W | Per-unit collected source values |

## Verification
The bench builds the block with the defaults: four collector units, four banks, four warps of sixteen registers and three source slots. With only four units, four back-to-back issues fill the block and expose the refusal path. With four banks and four warps, R0/R4/R8 of warp 0 give a three-way bank collision, while R4 of warp 1 is moved into a free bank by the swizzle. Issue orders are chosen so that an older instruction sits in a higher-numbered unit, which separates age priority from index priority.

// File: rtl/operand_collector.sv
module operand_collector #(
  parameter int NUM_CU    = 4,
  parameter int NUM_BANKS = 4,
  parameter int NUM_WARPS = 4,
  parameter int NUM_REGS  = 16,
  parameter int DATA_W    = 32,
  parameter int OP_W      = 6,
  parameter int NSRC      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          issue_valid,
  output logic                          issue_ready,
  input  logic [$clog2(NUM_WARPS)-1:0]  issue_warp,
  input  logic [OP_W-1:0]               issue_op,
  input  logic [NSRC-1:0]               issue_src_en,
  input  logic [NSRC*$clog2(NUM_REGS)-1:0] issue_src,
  input  logic                          wb_valid,
  input  logic [$clog2(NUM_WARPS)-1:0]  wb_warp,
  input  logic [$clog2(NUM_REGS)-1:0]   wb_reg,
  input  logic [DATA_W-1:0]             wb_data,
  output logic [NUM_CU-1:0]             disp_valid,
  output logic [NUM_CU*$clog2(NUM_WARPS)-1:0] disp_warp,
  output logic [NUM_CU*OP_W-1:0]        disp_op,
  output logic [NUM_CU*NSRC*DATA_W-1:0] disp_operands
);
  localparam int WID_W  = $clog2(NUM_WARPS);
  localparam int REG_W  = $clog2(NUM_REGS);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int MEM_D  = NUM_WARPS * NUM_REGS;
  localparam int MEM_W  = $clog2(MEM_D);

  function automatic logic [BANK_W-1:0] bank_of(input logic [WID_W-1:0] w, input logic [REG_W-1:0] r);
    int sum;
    sum = int'(r) + int'(w);
    return BANK_W'(sum % NUM_BANKS);
  endfunction

  function automatic logic [MEM_W-1:0] cell_of(input logic [WID_W-1:0] w, input logic [REG_W-1:0] r);
    return MEM_W'(int'(w) * NUM_REGS + int'(r));
  endfunction

  logic [DATA_W-1:0] mem [MEM_D];

  logic [NUM_CU-1:0] busy, done, alloc;
  logic [NUM_CU-1:0] older [NUM_CU];
  logic [WID_W-1:0]  cu_warp [NUM_CU];
  logic [OP_W-1:0]   cu_op   [NUM_CU];
  logic [NSRC-1:0]   cu_pend [NUM_CU];
  logic [REG_W-1:0]  cu_reg  [NUM_CU][NSRC];
  logic [DATA_W-1:0] cu_data [NUM_CU][NSRC];

  logic [NUM_BANKS-1:0] ureq [NUM_CU];
  logic [SEL_W-1:0]     usel [NUM_CU][NUM_BANKS];
  logic [NUM_CU-1:0]    bgnt [NUM_BANKS];
  logic [NSRC-1:0]      sgnt [NUM_CU];
  logic [BANK_W-1:0]    wb_bank;
  logic                 fire;

  assign wb_bank     = bank_of(wb_warp, wb_reg);
  assign issue_ready = ~&busy;
  assign fire        = issue_valid && issue_ready;

  always_comb begin
    alloc = '0;
    for (int i = 0; i < NUM_CU; i++)
      if (!busy[i] && alloc == '0) alloc[i] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_CU; i++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        ureq[i][b] = 1'b0;
        usel[i][b] = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
          if (busy[i] && !done[i] && cu_pend[i][s] &&
              bank_of(cu_warp[i], cu_reg[i][s]) == BANK_W'(b)) begin
            ureq[i][b] = 1'b1;
            usel[i][b] = SEL_W'(s);
          end
        end
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int i = 0; i < NUM_CU; i++) begin
        bgnt[b][i] = ureq[i][b] && !(wb_valid && wb_bank == BANK_W'(b));
        for (int j = 0; j < NUM_CU; j++)
          if (j != i && ureq[j][b] && older[j][i]) bgnt[b][i] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CU; i++) begin
      sgnt[i] = '0;
      for (int b = 0; b < NUM_BANKS; b++)
        if (bgnt[b][i]) sgnt[i][usel[i][b]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
      done <= '0;
      for (int i = 0; i < NUM_CU; i++) begin
        cu_pend[i] <= '0;
        older[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_CU; i++) begin
        if (done[i]) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
        end else if (busy[i]) begin
          cu_pend[i] <= cu_pend[i] & ~sgnt[i];
          if ((cu_pend[i] & ~sgnt[i]) == '0) done[i] <= 1'b1;
        end else if (fire && alloc[i]) begin
          busy[i]    <= 1'b1;
          cu_pend[i] <= issue_src_en;
        end
        for (int j = 0; j < NUM_CU; j++) begin
          if (fire && alloc[i]) older[i][j] <= 1'b0;
          else if (fire && alloc[j] && i != j) older[i][j] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CU; i++) begin
      if (!busy[i] && fire && alloc[i]) begin
        cu_warp[i] <= issue_warp;
        cu_op[i]   <= issue_op;
        for (int s = 0; s < NSRC; s++) begin
          cu_reg[i][s]  <= issue_src[s*REG_W +: REG_W];
          cu_data[i][s] <= '0;
        end
      end else begin
        for (int s = 0; s < NSRC; s++)
          if (sgnt[i][s]) cu_data[i][s] <= mem[cell_of(cu_warp[i], cu_reg[i][s])];
      end
    end
    if (wb_valid) mem[cell_of(wb_warp, wb_reg)] <= wb_data;
  end

  for (genvar u = 0; u < NUM_CU; u++) begin : g_out
    assign disp_valid[u]                 = done[u];
    assign disp_warp[u*WID_W +: WID_W]   = cu_warp[u];
    assign disp_op[u*OP_W +: OP_W]       = cu_op[u];
    for (genvar s = 0; s < NSRC; s++) begin : g_slot
      assign disp_operands[(u*NSRC+s)*DATA_W +: DATA_W] = cu_data[u][s];
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done[u] |=> (!done[u] && !busy[u]));
    a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done[u] |-> busy[u]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    a_r2_one_read_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bgnt[b]));
    a_r5_writeback_owns_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_bank == BANK_W'(b)) |-> (bgnt[b] == '0));
    for (genvar i = 0; i < NUM_CU; i++) begin : g_i
      for (genvar j = 0; j < NUM_CU; j++) begin : g_j
        if (i != j) begin : g_pair
          a_r6_oldest_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (bgnt[b][i] && ureq[j][b]) |-> older[i][j]);
        end
      end
    end
  end

  a_r1_no_issue_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_ready |=> ((busy & ~$past(busy)) == '0));

endmodule

// File: tb/test_operand_collector.sv
`timescale 1ns/1ps
module test_operand_collector;
  localparam int NCU = 4, NSRC = 3, DW = 32, OPW = 6, RW = 4, WW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic [WW-1:0] issue_warp = '0;
  logic [OPW-1:0] issue_op = '0;
  logic [NSRC-1:0] issue_src_en = '0;
  logic [NSRC*RW-1:0] issue_src = '0;
  logic wb_valid = 1'b0;
  logic [WW-1:0] wb_warp = '0;
  logic [RW-1:0] wb_reg = '0;
  logic [DW-1:0] wb_data = '0;
  logic [NCU-1:0] disp_valid;
  logic [NCU*WW-1:0] disp_warp;
  logic [NCU*OPW-1:0] disp_op;
  logic [NCU*NSRC*DW-1:0] disp_operands;

  int checks = 0, fails = 0;
  logic [DW-1:0] mdl [64];

  always #4 clk = ~clk;

  operand_collector i_operand_collector (
    .clk, .rst_n, .issue_valid, .issue_ready, .issue_warp, .issue_op,
    .issue_src_en, .issue_src, .wb_valid, .wb_warp, .wb_reg, .wb_data,
    .disp_valid, .disp_warp, .disp_op, .disp_operands);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wb(input int w, input int r, input logic [DW-1:0] d);
    wb_valid = 1'b1; wb_warp = WW'(w); wb_reg = RW'(r); wb_data = d;
    mdl[w*16+r] = d;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic issue(input int w, input int op, input logic [2:0] en, input int r0, input int r1, input int r2);
    issue_valid = 1'b1; issue_warp = WW'(w); issue_op = OPW'(op); issue_src_en = en;
    issue_src = {RW'(r2), RW'(r1), RW'(r0)};
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic wait_disp(input int u, output int k);
    k = 0;
    while (!disp_valid[u] && k < 60) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic chk_disp(input string req, input int u, input int w, input int op,
                          input logic [2:0] en, input int r0, input int r1, input int r2);
    int regs [3];
    regs[0] = r0; regs[1] = r1; regs[2] = r2;
    chk(req, disp_warp[u*WW +: WW], w);
    chk(req, disp_op[u*OPW +: OPW], op);
    for (int s = 0; s < NSRC; s++)
      chk(req, disp_operands[(u*NSRC+s)*DW +: DW], en[s] ? mdl[w*16+regs[s]] : '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 ready after reset", issue_ready, 1);
    chk("R9 no dispatch after reset", disp_valid, 0);
  endtask

  task automatic t_distinct;
    int k;
    issue(0, 5, 3'b111, 1, 2, 3);
    wait_disp(0, k);
    chk("R3 distinct banks latency", k, 1);
    chk_disp("R8 operands distinct", 0, 0, 5, 3'b111, 1, 2, 3);
    @(negedge clk);
    chk("R7 pulse ends", disp_valid[0], 0);
    chk("R7 unit free again", issue_ready, 1);
    idle(2);
  endtask

  task automatic t_same_bank;
    int k;
    issue(0, 6, 3'b111, 0, 4, 8);
    wait_disp(0, k);
    chk("R2 same bank serialises", k, 3);
    chk_disp("R8 operands same bank", 0, 0, 6, 3'b111, 0, 4, 8);
    idle(3);
  endtask

  task automatic t_partial;
    int k;
    issue(2, 7, 3'b010, 9, 5, 11);
    wait_disp(0, k);
    chk("R8 partial latency", k, 1);
    chk_disp("R8 unused slots zero", 0, 2, 7, 3'b010, 9, 5, 11);
    idle(3);
    issue(1, 8, 3'b000, 0, 0, 0);
    wait_disp(0, k);
    chk("R8 no-source latency", k, 1);
    chk_disp("R8 no-source slots", 0, 1, 8, 3'b000, 0, 0, 0);
    idle(3);
  endtask

  task automatic t_swizzle;
    int k;
    issue(0, 9, 3'b111, 0, 4, 8);
    issue(1, 10, 3'b001, 4, 0, 0);
    wait_disp(1, k);
    chk("R4 swizzled warp avoids conflict", k, 1);
    chk("R1 second issue in unit 1", disp_op[1*OPW +: OPW], 10);
    chk_disp("R4 swizzled operand", 1, 1, 10, 3'b001, 4, 0, 0);
    wait_disp(0, k);
    chk("R2 older chain still serial", k, 1);
    idle(3);
  endtask

  task automatic t_oldest;
    int k;
    issue(3, 11, 3'b000, 0, 0, 0);
    issue(0, 12, 3'b111, 0, 4, 8);
    idle(1);
    issue(0, 13, 3'b001, 12, 0, 0);
    wait_disp(1, k);
    chk("R6 older high-index unit wins", k, 1);
    chk_disp("R6 older operands", 1, 0, 12, 3'b111, 0, 4, 8);
    @(negedge clk);
    wait_disp(0, k);
    chk("R6 younger low-index unit waits", k, 0);
    chk_disp("R6 younger operands", 0, 0, 13, 3'b001, 12, 0, 0);
    idle(3);
  endtask

  task automatic t_writeback;
    int k;
    issue_valid = 1'b1; issue_warp = 0; issue_op = 14; issue_src_en = 3'b011;
    issue_src = {RW'(0), RW'(5), RW'(1)};
    wb_valid = 1'b1; wb_warp = 3; wb_reg = 2; wb_data = 32'h1111_2222;
    mdl[3*16+2] = 32'h1111_2222;
    @(negedge clk);
    issue_valid = 1'b0;
    wb_warp = 0; wb_reg = 1; wb_data = 32'h5EED_0001;
    mdl[1] = 32'h5EED_0001;
    @(negedge clk);
    wb_valid = 1'b0;
    wait_disp(0, k);
    chk("R5 writeback delays bank reads", k, 2);
    chk_disp("R5 read sees written value", 0, 0, 14, 3'b011, 1, 5, 0);
    idle(3);
  endtask

  task automatic t_full;
    int n, bad;
    int order [4];
    issue(0, 20, 3'b111, 0, 4, 8);
    issue(0, 21, 3'b111, 0, 4, 8);
    issue(0, 22, 3'b111, 0, 4, 8);
    issue(0, 23, 3'b111, 0, 4, 8);
    chk("R1 ready low when full", issue_ready, 0);
    issue_valid = 1'b1; issue_warp = 1; issue_op = 63; issue_src_en = 3'b000;
    n = 0; bad = 0;
    for (int c = 0; c < 40; c++) begin
      for (int u = 0; u < NCU; u++) begin
        if (disp_valid[u]) begin
          if (disp_op[u*OPW +: OPW] == 63) bad++;
          if (n < 4) order[n] = int'(disp_op[u*OPW +: OPW]);
          n++;
        end
      end
      @(negedge clk);
      issue_valid = 1'b0;
    end
    chk("R1 refused issue never dispatches", bad, 0);
    chk("R1 exactly four dispatches", n, 4);
    for (int q = 0; q < 4; q++) chk("R6 age order under contention", order[q], 20 + q);
    chk("R1 ready after drain", issue_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    for (int w = 0; w < 4; w++)
      for (int r = 0; r < 16; r++)
        wb(w, r, 32'hA000_0000 | (w << 8) | r);
    t_distinct;
    t_same_bank;
    t_partial;
    t_swizzle;
    t_oldest;
    t_writeback;
    t_full;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule